// File: doc/BRIEF.md
# ADC Engine Register Window Monitor

This block is the register file of one engine of a multi-channel analog-to-digital converter. A single-cycle, word-addressed read/write bus reaches all of its registers: the engine control, interrupt control, display-detect control, clock control, interrupt source and trim registers, plus the per-channel data, bounds and hysteresis registers. Each data register packs the samples of one even/odd channel pair. No real conversion takes place. Reading a data register returns its current contents and then steps both samples by fixed increments, so software sees a moving sequence.

After every data read, a two-state evaluation machine checks the freshly advanced pair against the two bounds registers of its channels. If either sample falls outside its window, the machine latches a per-pair flag in interrupt control, and the level interrupt output follows those flags. The machine has two states. `EV_IDLE` is the state with no pending check. `EV_CHECK` is the cycle in which the advanced pair is compared with its bounds. The transition `EV_IDLE -> EV_CHECK` and the transition `EV_CHECK -> EV_CHECK` are both taken on any accepted data read. The transition `EV_CHECK -> EV_IDLE` is taken when no data read is accepted. A parameter selects 8 or 16 channels.

Top module: `adc_window_regs`

## Requirements
- R1: After reset, display-detect control (word 2) and clock control (word 3) read 0x0000000F, every other register reads zero, and `irq_o` is low.
- R2: Word addresses are as follows: engine control 0, interrupt control 1, display-detect control 2, clock control 3, data pair n at 4+n (n = 0..7), bounds for channel c at 12+c, hysteresis for channel c at 28+c (c = 0..15), interrupt source 48, trim 49.
- R3: A data register holds the even channel in bits 9:0 and the odd channel in bits 25:16. A read returns the current value. In the same edge, bits 9:0 become (value+5) mod 1024 and bits 25:16 become (value+7) mod 1024.
- R4: A bounds register holds the lower limit in bits 9:0 and the upper limit in bits 25:16. Pair n is checked against bounds 2n (even channel) and 2n+1 (odd channel). A sample that is strictly below its lower limit or strictly above its upper limit sets bit n of interrupt control. The check uses the advanced pair on the edge after the read, so the flag appears two edges after the read is presented.
- R5: `irq_o` is high exactly when any of bits 7:0 of interrupt control is set. A flag stays set until software writes interrupt control. Such a write stores all 32 bits, and a flag raised in the same cycle is ORed in.
- R6: A write to engine control stores bit 8 equal to written bit 0 and forces bit 5 to 0. All other bits are stored as written.
- R7: Write masks are as follows: data and bounds keep bits 25:16 and 9:0; hysteresis keeps bits 31, 25:16 and 9:0; interrupt source keeps bits 15:0; trim keeps bits 3:0. Display-detect and clock control keep all bits.
- R8: On reads, `bus_lanes` = 2'b10 returns bits 31:16 of the register in bits 15:0, zero-extended. 2'b01 returns bits 15:0, zero-extended. 2'b11 or 2'b00 returns the whole word. A data read still advances the samples for every lane setting. Writes ignore `bus_lanes`.
- R9: With 8 channels, data pairs 4–7, bounds 8–15 and hysteresis 8–15 read zero and discard writes. A read of such a data pair advances nothing and raises no flag.
- R10: Unmapped word addresses read zero and ignore writes.
- R11: `rd_data` is registered. It takes the read value on the edge that accepts a read and holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_lanes | input | 2 | Read half select (see R8) |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
Read data is due one edge after the access is presented. The bench drives on the falling edge and samples just after the next rising edge. A data read advances the register on that same edge, so the next read of the pair must return the stepped value. The window flag is due one edge later still. The bench therefore checks that `irq_o` is still low right after the read, then waits one more rising edge before expecting the flag. Boundary values land exactly on, and one past, each limit.

// File: rtl/adcw_pkg.sv
package adcw_pkg;

    localparam int DW     = 32;
    localparam int SW     = 10;
    localparam int AW     = 6;

    localparam logic [AW-1:0] A_CTRL = 6'd0;
    localparam logic [AW-1:0] A_IRQ  = 6'd1;
    localparam logic [AW-1:0] A_VGA  = 6'd2;
    localparam logic [AW-1:0] A_CLK  = 6'd3;
    localparam logic [AW-1:0] A_DATA = 6'd4;
    localparam logic [AW-1:0] A_BND  = 6'd12;
    localparam logic [AW-1:0] A_HYS  = 6'd28;
    localparam logic [AW-1:0] A_ISRC = 6'd48;
    localparam logic [AW-1:0] A_TRIM = 6'd49;

    localparam int MAX_PAIRS = 8;
    localparam int MAX_CH    = 16;

    localparam logic [DW-1:0] MASK_PAIR = 32'h03FF_03FF;
    localparam logic [DW-1:0] MASK_HYS  = 32'h83FF_03FF;
    localparam logic [DW-1:0] MASK_ISRC = 32'h0000_FFFF;
    localparam logic [DW-1:0] MASK_TRIM = 32'h0000_000F;
    localparam logic [DW-1:0] RST_VGA   = 32'h0000_000F;
    localparam logic [DW-1:0] RST_CLK   = 32'h0000_000F;

    localparam logic [SW-1:0] STEP_EVEN = 10'd5;
    localparam logic [SW-1:0] STEP_ODD  = 10'd7;

    localparam int BIT_EN   = 0;
    localparam int BIT_ACMP = 5;
    localparam int BIT_INIT = 8;

    typedef enum logic [3:0] {
        K_NONE, K_CTRL, K_IRQ, K_VGA, K_CLK,
        K_DATA, K_BND, K_HYS, K_ISRC, K_TRIM
    } reg_kind_t;

    typedef enum logic {
        EV_IDLE,
        EV_CHECK
    } ev_state_t;

    function automatic logic [SW-1:0] lo_field(input logic [DW-1:0] v);
        return v[SW-1:0];
    endfunction

    function automatic logic [SW-1:0] hi_field(input logic [DW-1:0] v);
        return v[16+SW-1:16];
    endfunction

    function automatic logic [DW-1:0] step_pair(input logic [DW-1:0] v);
        logic [SW-1:0] lo_n;
        logic [SW-1:0] hi_n;
        lo_n = lo_field(v) + STEP_EVEN;
        hi_n = hi_field(v) + STEP_ODD;
        return {6'b0, hi_n, 6'b0, lo_n};
    endfunction

    function automatic logic [DW-1:0] fix_ctrl(input logic [DW-1:0] v);
        logic [DW-1:0] r;
        r = v;
        r[BIT_INIT] = v[BIT_EN];
        r[BIT_ACMP] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/adcw_decode.sv
module adcw_decode
    import adcw_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic [AW-1:0] addr,
    output reg_kind_t     kind,
    output logic [3:0]    idx
);
    localparam int NPAIR = NUM_CH / 2;

    logic [AW-1:0] off;

    always_comb begin
        kind = K_NONE;
        idx  = '0;
        off  = '0;
        if (addr == A_CTRL) begin
            kind = K_CTRL;
        end else if (addr == A_IRQ) begin
            kind = K_IRQ;
        end else if (addr == A_VGA) begin
            kind = K_VGA;
        end else if (addr == A_CLK) begin
            kind = K_CLK;
        end else if (addr >= A_DATA && addr < A_BND) begin
            off = addr - A_DATA;
            idx = off[3:0];
            if (int'(off) < NPAIR) kind = K_DATA;
        end else if (addr >= A_BND && addr < A_HYS) begin
            off = addr - A_BND;
            idx = off[3:0];
            if (int'(off) < NUM_CH) kind = K_BND;
        end else if (addr >= A_HYS && addr < A_HYS + 6'd16) begin
            off = addr - A_HYS;
            idx = off[3:0];
            if (int'(off) < NUM_CH) kind = K_HYS;
        end else if (addr == A_ISRC) begin
            kind = K_ISRC;
        end else if (addr == A_TRIM) begin
            kind = K_TRIM;
        end
    end
endmodule

// File: rtl/adcw_window.sv
module adcw_window
    import adcw_pkg::*;
(
    input  logic [DW-1:0] pair,
    input  logic [DW-1:0] even_bnd,
    input  logic [DW-1:0] odd_bnd,
    output logic          outside
);
    logic even_out;
    logic odd_out;

    always_comb begin
        even_out = (lo_field(pair) < lo_field(even_bnd)) ||
                   (lo_field(pair) > hi_field(even_bnd));
        odd_out  = (hi_field(pair) < lo_field(odd_bnd)) ||
                   (hi_field(pair) > hi_field(odd_bnd));
        outside  = even_out || odd_out;
    end
endmodule

// File: rtl/adcw_eval_fsm.sv
module adcw_eval_fsm
    import adcw_pkg::*;
#(
    parameter int PIW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [PIW-1:0] start_idx,
    output logic           busy,
    output logic [PIW-1:0] cur_idx
);
    ev_state_t      state_q;
    ev_state_t      state_d;
    logic [PIW-1:0] idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE:  state_d = start ? EV_CHECK : EV_IDLE;
            EV_CHECK: state_d = start ? EV_CHECK : EV_IDLE;
            default:  state_d = EV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EV_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start) idx_q <= start_idx;
        end
    end

    always_comb begin
        busy    = 1'b0;
        cur_idx = idx_q;
        unique case (state_q)
            EV_IDLE:  busy = 1'b0;
            EV_CHECK: busy = 1'b1;
            default:  busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_window_regs.sv
module adc_window_regs
    import adcw_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [5:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    input  logic [1:0]    bus_lanes,
    output logic [31:0]   rd_data,
    output logic          irq_o
);
    localparam int NPAIR = NUM_CH / 2;
    localparam int PIW   = $clog2(NPAIR);
    localparam int CIW   = $clog2(NUM_CH);

    initial begin
        if (NUM_CH != 8 && NUM_CH != 16)
            $error("NUM_CH must be 8 or 16");
    end

    reg_kind_t      dec_kind;
    logic [3:0]     dec_idx;
    logic [PIW-1:0] pidx;
    logic [CIW-1:0] cidx;
    logic           wr_acc;
    logic           rd_acc;
    logic           acc_data;

    logic [DW-1:0]  ctrl_q, irq_q, vga_q, clk_q, isrc_q, trim_q;
    logic [DW-1:0]  data_q [NPAIR];
    logic [DW-1:0]  bnd_q  [NUM_CH];
    logic [DW-1:0]  hys_q  [NUM_CH];
    logic [DW-1:0]  rd_q;
    logic [DW-1:0]  rd_val;
    logic [DW-1:0]  rd_lane;
    logic [DW-1:0]  sel_pair;
    logic [DW-1:0]  flag_vec;

    logic           ev_busy;
    logic [PIW-1:0] ev_idx;
    logic           ev_out;

    adcw_decode #(.NUM_CH(NUM_CH)) u_dec (
        .addr (bus_addr),
        .kind (dec_kind),
        .idx  (dec_idx)
    );

    assign pidx     = dec_idx[PIW-1:0];
    assign cidx     = dec_idx[CIW-1:0];
    assign wr_acc   = bus_en && bus_we;
    assign rd_acc   = bus_en && !bus_we;
    assign acc_data = (dec_kind == K_DATA);
    assign sel_pair = data_q[pidx];

    adcw_eval_fsm #(.PIW(PIW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (rd_acc && acc_data),
        .start_idx (pidx),
        .busy      (ev_busy),
        .cur_idx   (ev_idx)
    );

    adcw_window u_win (
        .pair     (data_q[ev_idx]),
        .even_bnd (bnd_q[{ev_idx, 1'b0}]),
        .odd_bnd  (bnd_q[{ev_idx, 1'b1}]),
        .outside  (ev_out)
    );

    always_comb begin
        flag_vec = '0;
        if (ev_busy && ev_out) flag_vec[ev_idx] = 1'b1;
    end

    // Data pairs: write masked, read advances.
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[p] <= '0;
            end else if (acc_data && pidx == PIW'(p)) begin
                if (wr_acc)      data_q[p] <= bus_wdata & MASK_PAIR;
                else if (rd_acc) data_q[p] <= step_pair(data_q[p]);
            end
        end
    end

    // Per-channel bounds and hysteresis.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bnd_q[c] <= '0;
                hys_q[c] <= '0;
            end else if (wr_acc && cidx == CIW'(c)) begin
                if (dec_kind == K_BND) bnd_q[c] <= bus_wdata & MASK_PAIR;
                if (dec_kind == K_HYS) hys_q[c] <= bus_wdata & MASK_HYS;
            end
        end
    end

    // Scalar control registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            irq_q  <= '0;
            vga_q  <= RST_VGA;
            clk_q  <= RST_CLK;
            isrc_q <= '0;
            trim_q <= '0;
        end else begin
            if (wr_acc && dec_kind == K_IRQ) irq_q <= bus_wdata | flag_vec;
            else                             irq_q <= irq_q | flag_vec;
            if (wr_acc) begin
                unique case (dec_kind)
                    K_CTRL:  ctrl_q <= fix_ctrl(bus_wdata);
                    K_VGA:   vga_q  <= bus_wdata;
                    K_CLK:   clk_q  <= bus_wdata;
                    K_ISRC:  isrc_q <= bus_wdata & MASK_ISRC;
                    K_TRIM:  trim_q <= bus_wdata & MASK_TRIM;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_val = '0;
        unique case (dec_kind)
            K_CTRL:  rd_val = ctrl_q;
            K_IRQ:   rd_val = irq_q;
            K_VGA:   rd_val = vga_q;
            K_CLK:   rd_val = clk_q;
            K_DATA:  rd_val = sel_pair;
            K_BND:   rd_val = bnd_q[cidx];
            K_HYS:   rd_val = hys_q[cidx];
            K_ISRC:  rd_val = isrc_q;
            K_TRIM:  rd_val = trim_q;
            default: rd_val = '0;
        endcase
        unique case (bus_lanes)
            2'b10:   rd_lane = {16'h0, rd_val[31:16]};
            2'b01:   rd_lane = {16'h0, rd_val[15:0]};
            default: rd_lane = rd_val;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_q <= '0;
        else if (rd_acc) rd_q <= rd_lane;
    end

    assign rd_data = rd_q;
    assign irq_o   = |irq_q[7:0];

endmodule

// File: rtl/adcw_checker.sv
module adcw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_en,
    input logic        bus_we,
    input logic [5:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [1:0]  bus_lanes,
    input logic [31:0] rd_data,
    input logic        irq_o,
    input logic        acc_data,
    input logic [31:0] sel_pair,
    input logic [31:0] ctrl_q,
    input logic        ev_busy,
    input logic        ev_out
);
    // R3: a full-word data read returns the pair as held before the step
    p_rd_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en && !bus_we && acc_data && bus_lanes == 2'b11
        |=> rd_data == $past(sel_pair));

    // R8: the upper-half read returns the high 16 bits in the low half
    p_upper_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en && !bus_we && acc_data && bus_lanes == 2'b10
        |=> rd_data == {16'h0, $past(sel_pair[31:16])});

    // R4: every data read is followed by a window check
    p_eval_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en && !bus_we && acc_data |=> ev_busy);

    // R4: a failed window check raises the interrupt
    p_flag_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_busy && ev_out |=> irq_o);

    // R5: the interrupt stays up until interrupt control is written
    p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !(bus_en && bus_we && bus_addr == 6'd1) |=> irq_o);

    // R6: init follows enable and auto-compensate is cleared
    p_ctrl_fix_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en && bus_we && bus_addr == 6'd0
        |=> ctrl_q[8] == $past(bus_wdata[0]) && !ctrl_q[5]);

    // R11: read data holds when no read is accepted
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && !bus_we) |=> $stable(rd_data));
endmodule

bind adc_window_regs adcw_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_lanes (bus_lanes),
    .rd_data   (rd_data),
    .irq_o     (irq_o),
    .acc_data  (acc_data),
    .sel_pair  (sel_pair),
    .ctrl_q    (ctrl_q),
    .ev_busy   (ev_busy),
    .ev_out    (ev_out)
);

// File: tb/adc_window_regs_tb.sv
module adc_window_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 8;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_lanes = 2'b11;
    logic [31:0] rd_data;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_window_regs #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_lanes(bus_lanes),
        .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 6'(a); bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input int a, input logic [1:0] ln, output logic [31:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 6'(a); bus_lanes = ln;
        @(posedge clk);
        #1 v = rd_data;
        @(negedge clk);
        bus_en = 1'b0; bus_lanes = 2'b11;
    endtask

    // Value after writing all ones (R2, R6, R7, R9, R10) for 8 channels.
    function automatic logic [31:0] exp_ones(input int w);
        if (w == 0) return 32'hFFFF_FFDF;
        if (w >= 1 && w <= 3) return 32'hFFFF_FFFF;
        if (w >= 4 && w < 4 + NCH/2) return 32'h03FF_03FF;
        if (w >= 12 && w < 12 + NCH) return 32'h03FF_03FF;
        if (w >= 28 && w < 28 + NCH) return 32'h83FF_03FF;
        if (w == 48) return 32'h0000_FFFF;
        if (w == 49) return 32'h0000_000F;
        return 32'h0;
    endfunction

    function automatic logic [31:0] stepped(input logic [31:0] v);
        int lo, hi;
        lo = (int'(v[9:0]) + 5) % 1024;
        hi = (int'(v[25:16]) + 7) % 1024;
        return (32'(hi) << 16) | 32'(lo);
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] model;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        for (int w = 0; w < 64; w++) begin
            bus_read(w, 2'b11, v);
            check("R1 reset value", v, (w == 2 || w == 3) ? 32'hF : 32'h0);
        end

        // R2/R6/R7/R9/R10 write all ones, read back
        for (int w = 0; w < 64; w++) bus_write(w, 32'hFFFF_FFFF);
        for (int w = 0; w < 64; w++) begin
            bus_read(w, 2'b11, v);
            check("R7 R9 R10 mask", v, exp_ones(w));
        end
        for (int w = 0; w < 64; w++) bus_write(w, 32'h0);
        bus_read(1, 2'b11, v);
        check("R5 cleared", v, 32'h0);
        for (int w = 12; w < 28; w++) begin
            bus_read(w, 2'b11, v);
            check("R7 zero write", v, 32'h0);
        end

        // R6 engine control rewrite
        bus_write(0, 32'h0000_0001); bus_read(0, 2'b11, v);
        check("R6 init from enable", v, 32'h0000_0101);
        bus_write(0, 32'h0000_0120); bus_read(0, 2'b11, v);
        check("R6 init cleared", v, 32'h0);
        bus_write(0, 32'h0000_FF3E); bus_read(0, 2'b11, v);
        check("R6 mixed", v, 32'h0000_FE1E);

        // R3 advance sweep with wrap, wide windows
        for (int c = 0; c < NCH; c++) bus_write(12 + c, 32'h03FF_0000);
        bus_write(1, 32'h0);
        for (int p = 0; p < NCH/2; p++) begin
            model = (32'(1000 + p*5) << 16) | 32'(1000 + p*3);
            bus_write(4 + p, model);
            for (int k = 0; k < 40; k++) begin
                bus_read(4 + p, 2'b11, v);
                check("R3 advance", v, model);
                model = stepped(model);
            end
        end
        @(posedge clk); #1;
        check("R4 no flag in window", {31'b0, irq_o}, 32'h0);

        // R4/R5 window boundaries per pair
        for (int p = 0; p < NCH/2; p++) begin
            bus_write(12 + 2*p,     (32'd200 << 16) | 32'd100);
            bus_write(12 + 2*p + 1, (32'd400 << 16) | 32'd300);
            for (int t = 0; t < 9; t++) begin
                int lo, hi;
                bit exp_f;
                if (t < 5) begin
                    case (t)
                        0: lo = 90; 1: lo = 94; 2: lo = 95; 3: lo = 195; default: lo = 196;
                    endcase
                    hi = 343;
                end else begin
                    case (t)
                        5: hi = 292; 6: hi = 293; 7: hi = 393; default: hi = 394;
                    endcase
                    lo = 145;
                end
                exp_f = (lo + 5 < 100) || (lo + 5 > 200) || (hi + 7 < 300) || (hi + 7 > 400);
                bus_write(4 + p, (32'(hi) << 16) | 32'(lo));
                bus_read(4 + p, 2'b11, v);
                check("R4 flag not early", {31'b0, irq_o}, 32'h0);
                @(posedge clk); #1;
                check("R4 R5 irq level", {31'b0, irq_o}, {31'b0, exp_f});
                bus_read(1, 2'b11, v);
                check("R4 flag bit", v, exp_f ? (32'h1 << p) : 32'h0);
                bus_write(1, 32'h0);
                @(posedge clk); #1;
                check("R5 cleared by write", {31'b0, irq_o}, 32'h0);
            end
        end

        // R5 sticky across other accesses
        bus_write(4, (32'd343 << 16) | 32'd10);
        bus_read(4, 2'b11, v);
        repeat (5) bus_read(0, 2'b11, v);
        check("R5 sticky", {31'b0, irq_o}, 32'h1);
        bus_write(1, 32'h0);

        // R8 half reads still advance
        for (int c = 0; c < 2; c++) bus_write(12 + c, 32'h03FF_0000);
        bus_write(4, 32'h0123_0045);
        bus_read(4, 2'b10, v); check("R8 upper half", v, 32'h0000_0123);
        bus_read(4, 2'b11, v); check("R8 advance after half", v, 32'h012A_004A);
        bus_read(4, 2'b01, v); check("R8 lower half", v, 32'h0000_004F);
        bus_read(4, 2'b00, v); check("R8 lanes zero full", v, 32'h0138_0054);

        // R11 hold between reads
        repeat (3) @(posedge clk); #1;
        check("R11 hold", rd_data, 32'h0138_0054);

        // R9 out-of-range pair: no advance, no flag
        bus_write(8, 32'h0000_0001);
        bus_read(8, 2'b11, v);
        check("R9 invalid pair reads zero", v, 32'h0);
        @(posedge clk); #1;
        check("R9 no flag", {31'b0, irq_o}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule